// File: doc/BRIEF.md
# Power-Management Command Mailbox

This block is a one-register mailbox that lets a host processor hand a command to a power or security co-processor and then poll for the outcome. The host writes the register over a simple register bus. On the other side, a one-cycle command strobe with a 7-bit code goes to the co-processor, and a completion strobe with a pass/fail flag comes back.

One 32-bit word carries three things. Bit 0 is the start/busy flag. Bits [7:1] hold the command code while the command is outstanding. After completion, the low byte holds the outcome. Before every command the host must first write an all-zero word. That write re-arms the mailbox and clears the previous outcome.

While a command is outstanding, a cycle counter runs. If the co-processor stays silent for the whole window, the mailbox gives up and reports failure itself. The default window is one second at the bus clock. A start write that arrives while a command is still outstanding is dropped, and bit 31 latches to record it.

Top module: `pmmbox_top`

## Requirements
- R1: After reset the register reads 0x0000_0000, `cmdValid` is low and the mailbox is not armed.
- R2: A write of 0x0000_0000 while idle arms the mailbox. The next write with bit 0 set and code C in bits [7:1] sets bit 0 to 1 and shows C in bits [7:1]. In the cycle after that write, it also raises `cmdValid` for exactly one cycle with `cmdCode` = C.
- R3: While bit 0 reads 1, bits [7:1] of the register and `cmdCode` stay constant.
- R4: A `respDone` pulse while busy clears bit 0 on the following edge. The low byte then reads 0x00 if `respFail` was 0 and 0xFE if `respFail` was 1.
- R5: If no `respDone` arrives, bit 0 clears and the low byte reads 0xFE exactly TIMEOUT_CYCLES cycles after the start write. TIMEOUT_CYCLES = CLK_HZ/1_000_000 × TIMEOUT_US.
- R6: A start write that is not preceded by an arming zero write is ignored: no `cmdValid`, and the register is unchanged.
- R7: A start write while bit 0 is 1 is ignored: no `cmdValid`, and the code is unchanged. It sets bit 31, which stays set until the next idle zero write.
- R8: A zero write while idle clears the low byte and bit 31. A zero write while busy has no effect.
- R9: `respDone` while idle is ignored. A `respDone` in the last cycle of the timeout window takes priority over the timeout.
- R10: The codes 0x00 (clock halt), 0x4A (random key), 0x55 (key restore) and 0x63 (fixed key) each pass unchanged to `cmdCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read value |
| cmdValid | output | 1 | One-cycle command strobe to the co-processor |
| cmdCode | output | 7 | Command code of the outstanding command |
| respDone | input | 1 | Completion strobe from the co-processor |
| respFail | input | 1 | Completion outcome, 1 = failure, sampled with respDone |

## Verification
A write seen at clock edge N is visible on `regRdData` just after edge N. `cmdValid` is high for the cycle between edges N and N+1. A completion driven before edge M shows its outcome just after edge M. The timeout outcome appears just after edge N+TIMEOUT_CYCLES.

The bench drives every stimulus at a falling edge and samples at the next falling edge. Each check therefore counts whole cycles from the edge that does the work. The timeout test looks one cycle before expiry and again at expiry. The priority test places the completion strobe on exactly the expiring edge.

// File: rtl/pmmbox_pkg.sv
package pmmbox_pkg;

  // Command codes understood by the co-processor
  typedef enum logic [6:0] {
    CMD_CLK_HALT    = 7'h00,
    CMD_KEY_RANDOM  = 7'h4A,
    CMD_KEY_RESTORE = 7'h55,
    CMD_KEY_FIXED   = 7'h63
  } mboxCmd_e;

  localparam logic [7:0] RES_OK   = 8'h00;
  localparam logic [7:0] RES_FAIL = 8'hFE;

  localparam int OVR_BIT  = 31;
  localparam int CODE_LSB = 1;
  localparam int CODE_W   = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic busy;
    logic startCmd;
    logic rejectStart;
    logic clearAll;
    logic finishOk;
    logic finishFail;
  } mboxStrobe_t;

endpackage

// File: rtl/pmmbox_ctrl.sv
module pmmbox_ctrl
  import pmmbox_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrZero,
  input  logic        wrStart,
  input  logic        respDone,
  input  logic        respFail,
  output mboxStrobe_t strobes
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             busy;
  logic             armed;
  logic [CNT_W-1:0] waitCnt;

  logic idleZero, startOk, reject, expire, doneNow, finOk, finFail;

  always_comb begin
    idleZero = wrEn && wrZero && !busy;
    startOk  = wrEn && wrStart && !busy && armed;
    reject   = wrEn && wrStart && busy;
    doneNow  = busy && respDone;
    expire   = busy && (waitCnt == CNT_LAST);
    finOk    = doneNow && !respFail;
    // a completion on the expiring edge outranks the timeout
    finFail  = (doneNow && respFail) || (expire && !respDone);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      armed   <= 1'b0;
      waitCnt <= '0;
    end else begin
      if (startOk) begin
        busy    <= 1'b1;
        armed   <= 1'b0;
        waitCnt <= '0;
      end else if (finOk || finFail) begin
        busy    <= 1'b0;
        waitCnt <= '0;
      end else if (busy) begin
        waitCnt <= waitCnt + 1'b1;
      end
      if (idleZero) armed <= 1'b1;
    end
  end

  always_comb begin
    strobes.busy        = busy;
    strobes.startCmd    = startOk;
    strobes.rejectStart = reject;
    strobes.clearAll    = idleZero;
    strobes.finishOk    = finOk;
    strobes.finishFail  = finFail;
  end

endmodule

// File: rtl/pmmbox_dpath.sv
module pmmbox_dpath
  import pmmbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobes,
  input  logic [CODE_W-1:0] wrCode,
  output logic [31:0]       rdData,
  output logic              cmdValid,
  output logic [CODE_W-1:0] cmdCode
);

  logic [CODE_W-1:0] codeReg;
  logic [7:0]        resultReg;
  logic              overrun;
  logic              validReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg   <= '0;
      resultReg <= '0;
      overrun   <= 1'b0;
      validReg  <= 1'b0;
    end else begin
      validReg <= strobes.startCmd;
      if (strobes.startCmd) codeReg <= wrCode;
      if (strobes.clearAll) begin
        resultReg <= '0;
        overrun   <= 1'b0;
      end else begin
        if (strobes.finishOk)    resultReg <= RES_OK;
        if (strobes.finishFail)  resultReg <= RES_FAIL;
        if (strobes.rejectStart) overrun   <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData          = '0;
    rdData[OVR_BIT] = overrun;
    if (strobes.busy) begin
      rdData[CODE_LSB +: CODE_W] = codeReg;
      rdData[0]                  = 1'b1;
    end else begin
      rdData[7:0] = resultReg;
    end
    cmdValid = validReg;
    cmdCode  = codeReg;
  end

endmodule

// File: rtl/pmmbox_top.sv
module pmmbox_top
  import pmmbox_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_US = 1_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        cmdValid,
  output logic [6:0]  cmdCode,
  input  logic        respDone,
  input  logic        respFail
);

  localparam int TIMEOUT_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  mboxStrobe_t strobes;

  pmmbox_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrZero   (regWrData == 32'h0),
    .wrStart  (regWrData[0]),
    .respDone (respDone),
    .respFail (respFail),
    .strobes  (strobes)
  );

  pmmbox_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrCode   (regWrData[CODE_LSB +: CODE_W]),
    .rdData   (regRdData),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode)
  );

endmodule

// File: rtl/pmmbox_checker.sv
module pmmbox_checker #(
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        cmdValid,
  input logic [6:0]  cmdCode,
  input logic        respDone,
  input logic        respFail
);

  logic busyQ;
  int   busyRun;

  assign busyQ = regRdData[0];

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else       busyRun <= busyQ ? busyRun + 1 : 0;
  end

  // R2: strobe lasts one cycle and coincides with busy
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busyQ);

  // R3: code held while outstanding
  a_r3_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ($stable(cmdCode) && $stable(regRdData[7:1])));

  // R4: completion clears busy on the next edge
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && respDone) |=> !busyQ);

  // R4 / R5: only two outcome encodings exist
  a_r4_result_code: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (regRdData[7:0] == 8'h00 || regRdData[7:0] == 8'hFE));

  // R5: busy never outlasts the window
  a_r5_window: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (busyRun < TIMEOUT_CYCLES));

  // R7: overrun flag is sticky until an idle zero write
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[31] && !(regWrEn && regWrData == 32'h0 && !busyQ)) |=> regRdData[31]);

  // R6 / R7: no strobe without a fresh accepted start
  a_r7_no_valid_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && busyQ) |=> !cmdValid);

  logic unusedFail;
  assign unusedFail = respFail;

endmodule

bind pmmbox_top pmmbox_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .cmdValid  (cmdValid),
  .cmdCode   (cmdCode),
  .respDone  (respDone),
  .respFail  (respFail)
);

// File: tb/test_pmmbox_top.sv
module test_pmmbox_top;

  localparam int LIMIT = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdValid;
  logic [6:0]  cmdCode;
  logic        respDone = 1'b0;
  logic        respFail = 1'b0;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  pmmbox_top #(.CLK_HZ(1_000_000), .TIMEOUT_US(LIMIT)) i_pmmbox_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .respDone(respDone), .respFail(respFail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic respond(input logic fail);
    respDone = 1'b1; respFail = fail;
    @(negedge clk);
    respDone = 1'b0; respFail = 1'b0;
  endtask

  // arm + start, check register and one-cycle strobe
  task automatic issue(input logic [6:0] code, input string req);
    regWrite(32'h0);
    regWrite({24'h0, code, 1'b1});
    check(req, regRdData, {24'h0, code, 1'b1});
    check(req, {31'h0, cmdValid}, 32'h1);
    check(req, {25'h0, cmdCode}, {25'h0, code});
    idle(1);
    check(req, {31'h0, cmdValid}, 32'h0);
  endtask

  task automatic tReset();
    check("R1 reset read", regRdData, 32'h0);
    check("R1 reset valid", {31'h0, cmdValid}, 32'h0);
    // R1/R6: unarmed after reset, start ignored
    regWrite(32'h0000_0095);
    check("R6 unarmed start", regRdData, 32'h0);
    check("R6 unarmed valid", {31'h0, cmdValid}, 32'h0);
  endtask

  task automatic tAllCodes();
    logic [6:0] codes [4] = '{7'h00, 7'h4A, 7'h55, 7'h63};
    for (int i = 0; i < 4; i++) begin
      issue(codes[i], "R10 code");
      idle(3);
      check("R3 held", regRdData[7:0], {codes[i], 1'b1});
      check("R3 cmdCode held", {25'h0, cmdCode}, {25'h0, codes[i]});
      respond(i[0]);
      check("R4 result", regRdData, i[0] ? 32'h0000_00FE : 32'h0);
    end
  endtask

  task automatic tNoRearm();
    issue(7'h55, "R2 start");
    respond(1'b1);
    check("R4 fail code", regRdData, 32'h0000_00FE);
    regWrite(32'h0000_00C7);
    check("R6 no rearm reg", regRdData, 32'h0000_00FE);
    check("R6 no rearm valid", {31'h0, cmdValid}, 32'h0);
    respond(1'b0);
    check("R9 idle done", regRdData, 32'h0000_00FE);
    regWrite(32'h0);
    check("R8 clear result", regRdData, 32'h0);
  endtask

  task automatic tOverrun();
    issue(7'h4A, "R2 start");
    regWrite(32'h0000_00C7);
    check("R7 overrun set", regRdData, 32'h8000_0095);
    check("R7 no valid", {31'h0, cmdValid}, 32'h0);
    regWrite(32'h0);
    check("R8 zero while busy", regRdData, 32'h8000_0095);
    respond(1'b0);
    check("R7 sticky", regRdData, 32'h8000_0000);
    regWrite(32'h0);
    check("R8 clear overrun", regRdData, 32'h0);
  endtask

  task automatic tTimeout();
    issue(7'h63, "R2 start");
    // issue consumed one cycle past the start edge
    idle(LIMIT - 2);
    check("R5 before expiry", regRdData, 32'h0000_00C7);
    idle(1);
    check("R5 timeout", regRdData, 32'h0000_00FE);
  endtask

  task automatic tDoneAtExpiry();
    issue(7'h00, "R2 start");
    idle(LIMIT - 2);
    respond(1'b0);  // sampled on the expiring edge
    check("R9 done wins", regRdData, 32'h0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    tReset();
    tAllCodes();
    tNoRearm();
    tOverrun();
    tTimeout();
    tDoneAtExpiry();
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule